// File: doc/BRIEF.md
# Banked Memory-Attribute Register Access Controller

This block holds a 32-bit memory-attribute word in two copies, one for the secure world and one for the non-secure world. Software reaches it through a coprocessor-style request port. Each request carries a decoded instruction encoding, a direction flag, write data, the requester's privilege level and a set of configuration bits. The block decides whether the access completes, is undefined, or traps to the hypervisor. It picks the copy to use and returns a registered response one clock after it accepts the request.

A second, purely combinational port serves translation hardware. A 3-bit attribute index selects one 8-bit field. Index bit 2 chooses between the local word (fields 0 to 3) and a companion word supplied from outside (fields 4 to 7). Index bits 1:0 choose byte n at bits [8n+7:8n]. The local word shown on this port is the copy that the current security configuration selects.

Top module: `sysreg_attr_bank`

## Requirements
- R1: Only coprocessor 15 with opc1=0, CRn=10, CRm=2, opc2=0 is claimed. Any other encoding gets result code 3 (not claimed) and writes nothing.
- R2: Any claimed access at privilege level 0 gets result code 1 (undefined).
- R3: At level 1, when the hypervisor is enabled and the per-register trap bit is set, the access gets code 2 (trap) with class 0x03. This check comes before every other level-1 check. The class output is 0 for every code other than 2.
- R4: At level 1 with the hypervisor enabled, a read traps (code 2, class 0x03) when the read-VM trap bit is set, and a write traps when the write-VM trap bit is set. Neither bit affects the other direction.
- R5: At levels 1 and 3, a write gets code 1 when the monitor level exists, the secure-state bit is 0 and the secure-write lock pin is high. At level 1 this check sits after the R3 check and before the R4 check. Reads are not affected.
- R6: At levels 1 and 3 with the monitor level present, secure-state bit 0 selects the secure copy and 1 selects the non-secure copy.
- R7: Level 2 accesses always complete (code 0) and always use the non-secure copy.
- R8: Without the monitor level, levels 1 and 2 share one copy (the non-secure slot), and level-3 accesses get code 1.
- R9: The lookup returns byte idx[1:0] of the companion word when idx[2]=1. When idx[2]=0 it returns that byte of the local copy, which is the secure copy only when the monitor exists and secure-state is 0.
- R10: After reset both copies read as zero and no response is valid.
- R11: A write that does not get code 0 leaves both copies unchanged. A response with a non-zero code carries zero read data, and a successful write returns zero data.
- R12: req_ready is always high. Every accepted request produces rsp_valid on the next clock. A successful read returns the copy's contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_cp | input | 4 | Coprocessor number |
| req_op1 | input | 3 | opc1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_op2 | input | 3 | opc2 field |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write value |
| req_lvl | input | 2 | Privilege level 0 to 3 |
| cfg_hyp_en | input | 1 | Hypervisor level enabled |
| cfg_reg_trap | input | 1 | Per-register hypervisor trap |
| cfg_vm_rd_trap | input | 1 | Read-direction VM trap |
| cfg_vm_wr_trap | input | 1 | Write-direction VM trap |
| cfg_mon | input | 1 | Monitor level exists |
| cfg_ns | input | 1 | Secure-state bit (1 = non-secure) |
| sec_wr_lock | input | 1 | Secure-write lock pin |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 ok, 1 undefined, 2 trap, 3 not claimed |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_rdata | output | 32 | Read data |
| lk_idx | input | 3 | Attribute index |
| lk_peer | input | 32 | Companion word holding fields 4 to 7 |
| lk_attr | output | 8 | Selected attribute field |

## Verification
A corrupted copy shows up at the lookup port in the same cycle it is written. It also shows up in the read data of the next successful read of that copy, one clock after acceptance. A write that lands in the wrong copy, or lands in a copy when it should have been blocked, shows up the same way: the unwritten copy is compared after every request. A wrong position in the priority chain shows up as a wrong result code on the response one clock after the request. The sweep covers every level against every combination of trap, monitor, secure-state and lock bits, so such a fault is seen on the first request whose bits expose it.

// File: rtl/attr_reg_pkg.sv
package attr_reg_pkg;

  typedef enum logic [1:0] {
    RC_OK    = 2'd0,
    RC_UNDEF = 2'd1,
    RC_TRAP  = 2'd2,
    RC_MISS  = 2'd3
  } rc_e;

  typedef struct packed {
    rc_e  code;
    logic use_ns;
  } verdict_t;

endpackage

// File: rtl/attr_access_judge.sv
module attr_access_judge
  import attr_reg_pkg::*;
(
  input  logic       hit,
  input  logic       is_write,
  input  logic [1:0] lvl,
  input  logic       hyp_en,
  input  logic       reg_trap,
  input  logic       vm_rd_trap,
  input  logic       vm_wr_trap,
  input  logic       mon,
  input  logic       ns,
  input  logic       lock,
  output verdict_t   verdict
);

  logic sec_wr_blocked;
  logic vm_trap;

  always_comb begin
    sec_wr_blocked = is_write && mon && !ns && lock;
    vm_trap        = hyp_en && (is_write ? vm_wr_trap : vm_rd_trap);
  end

  always_comb begin
    verdict.code   = RC_OK;
    verdict.use_ns = 1'b1;
    if (!hit) begin
      verdict.code = RC_MISS;
    end else begin
      unique case (lvl)
        2'd0: verdict.code = RC_UNDEF;
        2'd1: begin
          if (hyp_en && reg_trap)  verdict.code = RC_TRAP;
          else if (sec_wr_blocked) verdict.code = RC_UNDEF;
          else if (vm_trap)        verdict.code = RC_TRAP;
          else                     verdict.use_ns = mon ? ns : 1'b1;
        end
        2'd2: verdict.use_ns = 1'b1;
        default: begin
          if (!mon)                verdict.code = RC_UNDEF;
          else if (sec_wr_blocked) verdict.code = RC_UNDEF;
          else                     verdict.use_ns = ns;
        end
      endcase
    end
  end

endmodule

// File: rtl/attr_bank_pair.sv
module attr_bank_pair #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ns,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sec_q,
  output logic [DATA_W-1:0] ns_q
);

  logic [DATA_W-1:0] sec_d;
  logic [DATA_W-1:0] ns_d;
  logic              sec_en;
  logic              ns_en;

  always_comb begin
    sec_en = wr_en && !wr_ns;
    ns_en  = wr_en && wr_ns;
    sec_d  = sec_en ? wdata : sec_q;
    ns_d   = ns_en  ? wdata : ns_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

endmodule

// File: rtl/attr_field_pick.sv
module attr_field_pick #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIELD_W = 8,
  localparam int unsigned NFLD   = DATA_W / FIELD_W,
  localparam int unsigned IDX_W  = $clog2(2 * NFLD)
) (
  input  logic [DATA_W-1:0]  own_word,
  input  logic [DATA_W-1:0]  peer_word,
  input  logic [IDX_W-1:0]   idx,
  output logic [FIELD_W-1:0] field
);

  logic [FIELD_W-1:0] fields [2*NFLD];

  for (genvar g = 0; g < NFLD; g++) begin : g_split
    assign fields[g]        = own_word [g*FIELD_W +: FIELD_W];
    assign fields[g + NFLD] = peer_word[g*FIELD_W +: FIELD_W];
  end

  always_comb field = fields[idx];

endmodule

// File: rtl/sysreg_attr_bank.sv
module sysreg_attr_bank
  import attr_reg_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned CLASS_W    = 6,
  parameter logic [5:0]  TRAP_CLASS = 6'h03,
  parameter logic [3:0]  ENC_CP     = 4'd15,
  parameter logic [2:0]  ENC_OP1    = 3'd0,
  parameter logic [3:0]  ENC_CRN    = 4'd10,
  parameter logic [3:0]  ENC_CRM    = 4'd2,
  parameter logic [2:0]  ENC_OP2    = 3'd0,
  localparam int unsigned IDX_W     = $clog2(2 * (DATA_W / FIELD_W))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [3:0]         req_cp,
  input  logic [2:0]         req_op1,
  input  logic [3:0]         req_crn,
  input  logic [3:0]         req_crm,
  input  logic [2:0]         req_op2,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [1:0]         req_lvl,
  input  logic               cfg_hyp_en,
  input  logic               cfg_reg_trap,
  input  logic               cfg_vm_rd_trap,
  input  logic               cfg_vm_wr_trap,
  input  logic               cfg_mon,
  input  logic               cfg_ns,
  input  logic               sec_wr_lock,
  output logic               rsp_valid,
  output logic [1:0]         rsp_code,
  output logic [CLASS_W-1:0] rsp_class,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic [DATA_W-1:0]  lk_peer,
  output logic [FIELD_W-1:0] lk_attr
);

  logic               enc_hit;
  verdict_t           verdict;
  logic               accept;
  logic               commit;
  logic [DATA_W-1:0]  bank_sec;
  logic [DATA_W-1:0]  bank_ns;
  logic [DATA_W-1:0]  sel_word;
  logic [DATA_W-1:0]  lk_word;

  logic               rsp_valid_d;
  logic [1:0]         rsp_code_d;
  logic [CLASS_W-1:0] rsp_class_d;
  logic [DATA_W-1:0]  rsp_rdata_d;

  assign req_ready = 1'b1;

  always_comb begin
    enc_hit = (req_cp == ENC_CP) && (req_op1 == ENC_OP1) && (req_crn == ENC_CRN)
           && (req_crm == ENC_CRM) && (req_op2 == ENC_OP2);
    accept  = req_valid && req_ready;
    commit  = accept && req_write && (verdict.code == RC_OK);
  end

  attr_access_judge u_judge (
    .hit        (enc_hit),
    .is_write   (req_write),
    .lvl        (req_lvl),
    .hyp_en     (cfg_hyp_en),
    .reg_trap   (cfg_reg_trap),
    .vm_rd_trap (cfg_vm_rd_trap),
    .vm_wr_trap (cfg_vm_wr_trap),
    .mon        (cfg_mon),
    .ns         (cfg_ns),
    .lock       (sec_wr_lock),
    .verdict    (verdict)
  );

  attr_bank_pair #(.DATA_W(DATA_W)) u_banks (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (commit),
    .wr_ns (verdict.use_ns),
    .wdata (req_wdata),
    .sec_q (bank_sec),
    .ns_q  (bank_ns)
  );

  always_comb begin
    sel_word = verdict.use_ns ? bank_ns : bank_sec;
    lk_word  = (cfg_mon && !cfg_ns) ? bank_sec : bank_ns;
  end

  attr_field_pick #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_pick (
    .own_word  (lk_word),
    .peer_word (lk_peer),
    .idx       (lk_idx),
    .field     (lk_attr)
  );

  always_comb begin
    rsp_valid_d = accept;
    rsp_code_d  = accept ? verdict.code : RC_OK;
    rsp_class_d = (accept && verdict.code == RC_TRAP) ? TRAP_CLASS[CLASS_W-1:0] : '0;
    rsp_rdata_d = (accept && verdict.code == RC_OK && !req_write) ? sel_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rsp_class <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_code  <= rsp_code_d;
      rsp_class <= rsp_class_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

endmodule

// File: rtl/attr_reg_chk.sv
module attr_reg_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CLASS_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_lvl,
  input logic               hit,
  input logic               cfg_hyp_en,
  input logic               cfg_reg_trap,
  input logic               rsp_valid,
  input logic [1:0]         rsp_code,
  input logic [CLASS_W-1:0] rsp_class,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic [DATA_W-1:0]  bank_sec,
  input logic [DATA_W-1:0]  bank_ns
);

  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hit |=> rsp_code == 2'd3 && $stable(bank_sec) && $stable(bank_ns)); // R1

  AST_L0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit && req_lvl == 2'd0 |=> rsp_code == 2'd1); // R2

  AST_REG_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit && req_lvl == 2'd1 && cfg_hyp_en && cfg_reg_trap |=> rsp_code == 2'd2); // R3

  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == 2'd2 |-> rsp_class == CLASS_W'(3)); // R3

  AST_CLASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_code != 2'd2 |-> rsp_class == '0); // R3

  AST_ONE_COPY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !(bank_sec != $past(bank_sec) && bank_ns != $past(bank_ns))); // R6

  AST_L2_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit && req_lvl == 2'd2 |=> rsp_code == 2'd0 && $stable(bank_sec)); // R7

  AST_BANKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(bank_sec) && $stable(bank_ns)); // R11

  AST_FAIL_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code != 2'd0 |-> rsp_rdata == '0); // R11

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R12

endmodule

bind sysreg_attr_bank attr_reg_chk #(.DATA_W(DATA_W), .CLASS_W(CLASS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_lvl      (req_lvl),
  .hit          (enc_hit),
  .cfg_hyp_en   (cfg_hyp_en),
  .cfg_reg_trap (cfg_reg_trap),
  .rsp_valid    (rsp_valid),
  .rsp_code     (rsp_code),
  .rsp_class    (rsp_class),
  .rsp_rdata    (rsp_rdata),
  .bank_sec     (bank_sec),
  .bank_ns      (bank_ns)
);

// File: tb/sysreg_attr_bank_test.sv
module sysreg_attr_bank_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_cp;
  logic [2:0]  req_op1;
  logic [3:0]  req_crn;
  logic [3:0]  req_crm;
  logic [2:0]  req_op2;
  logic        req_write;
  logic [31:0] req_wdata;
  logic [1:0]  req_lvl;
  logic        cfg_hyp_en, cfg_reg_trap, cfg_vm_rd_trap, cfg_vm_wr_trap;
  logic        cfg_mon, cfg_ns, sec_wr_lock;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [5:0]  rsp_class;
  logic [31:0] rsp_rdata;
  logic [2:0]  lk_idx;
  logic [31:0] lk_peer;
  logic [7:0]  lk_attr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] ref_sec, ref_ns;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_attr_bank uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Behavioural reference: result code and whether the non-secure slot is used
  task automatic predict(input int lv, input bit wr, input bit hyp, input bit rtrap,
                         input bit vrd, input bit vwr, input bit mon, input bit ns,
                         input bit lock, output int code, output bit to_ns);
    bit lock_hit;
    lock_hit = wr && mon && !ns && lock;
    to_ns = 1;
    code  = 0;
    if (lv == 0) code = 1;
    else if (lv == 2) to_ns = 1;
    else if (lv == 3) begin
      if (!mon || lock_hit) code = 1;
      else to_ns = ns;
    end else begin
      if (hyp && rtrap) code = 2;
      else if (lock_hit) code = 1;
      else if (hyp && ((wr && vwr) || (!wr && vrd))) code = 2;
      else to_ns = mon ? ns : 1'b1;
    end
  endtask

  task automatic set_enc(input logic [3:0] cp, input logic [2:0] o1, input logic [3:0] cn,
                         input logic [3:0] cm, input logic [2:0] o2);
    req_cp = cp; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
  endtask

  // Compare every byte of both copies through the lookup port (R9, R6, R11)
  task automatic scan_copies(input string tag);
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 4; k++) begin
        cfg_mon = 1'b1; cfg_ns = b[0]; lk_idx = 3'(k);
        #1;
        check(tag, 32'(lk_attr), 32'((b == 0 ? ref_sec : ref_ns) >> (8*k)) & 32'hFF);
      end
    end
    cfg_mon = 1'b0; cfg_ns = 1'b0; lk_idx = 3'd1;
    #1;
    check({tag, " R8 single copy lookup"}, 32'(lk_attr), (ref_ns >> 8) & 32'hFF);
  endtask

  task automatic issue(input int lv, input logic [7:0] mb, input logic [31:0] wd,
                       input int exp_code, input bit exp_ns, input string tag);
    logic [31:0] exp_rd;
    @(negedge clk);
    req_lvl = 2'(lv); req_write = mb[0]; cfg_hyp_en = mb[1]; cfg_reg_trap = mb[2];
    cfg_vm_rd_trap = mb[3]; cfg_vm_wr_trap = mb[4]; cfg_mon = mb[5]; cfg_ns = mb[6];
    sec_wr_lock = mb[7]; req_wdata = wd; req_valid = 1'b1;
    exp_rd = (exp_code == 0 && !mb[0]) ? (exp_ns ? ref_ns : ref_sec) : 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R12 rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " code"}, 32'(rsp_code), 32'(exp_code));
    check({tag, " R3 class"}, 32'(rsp_class), exp_code == 2 ? 32'h3 : 32'h0);
    check({tag, " R11 rdata"}, rsp_rdata, exp_rd);
    if (exp_code == 0 && mb[0]) begin
      if (exp_ns) ref_ns = wd; else ref_sec = wd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int ec; bit en; int n;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; req_lvl = '0;
    cfg_hyp_en = 0; cfg_reg_trap = 0; cfg_vm_rd_trap = 0; cfg_vm_wr_trap = 0;
    cfg_mon = 0; cfg_ns = 0; sec_wr_lock = 0; lk_idx = '0; lk_peer = 32'hC3B2A190;
    set_enc(4'd15, 3'd0, 4'd10, 4'd2, 3'd0);
    ref_sec = '0; ref_ns = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R12 ready", 32'(req_ready), 32'd1);
    scan_copies("R10 reset copies");

    // R9: companion word fields 4..7
    for (int k = 4; k < 8; k++) begin
      lk_idx = 3'(k); #1;
      check("R9 peer field", 32'(lk_attr), (lk_peer >> (8*(k-4))) & 32'hFF);
    end

    // R7/R12: level-2 write then read back from the non-secure copy
    issue(2, 8'b0010_0001, 32'h1122_3344, 0, 1, "R7 L2 write");
    issue(2, 8'b0010_0000, 32'h0, 0, 1, "R12 L2 read");
    scan_copies("R7 after L2");

    // R1: each encoding field wrong in turn; write must not land
    for (int f = 0; f < 5; f++) begin
      set_enc(f == 0 ? 4'd14 : 4'd15, f == 1 ? 3'd1 : 3'd0, f == 2 ? 4'd9 : 4'd10,
              f == 3 ? 4'd3 : 4'd2, f == 4 ? 3'd4 : 3'd0);
      issue(2, 8'b0010_0001, 32'hDEAD_0000 + 32'(f), 3, 1, "R1 miss");
      scan_copies("R1 miss no write");
    end
    set_enc(4'd15, 3'd0, 4'd10, 4'd2, 3'd0);

    // Full sweep: R2 R3 R4 R5 R6 R7 R8 R11
    n = 0;
    for (int lv = 0; lv < 4; lv++) begin
      for (int m = 0; m < 256; m++) begin
        logic [7:0] mb;
        mb = 8'(m);
        predict(lv, mb[0], mb[1], mb[2], mb[3], mb[4], mb[5], mb[6], mb[7], ec, en);
        issue(lv, mb, 32'(n) * 32'h9E37_79B1 + 32'h0135_7BDF, ec, en,
              $sformatf("R2-chain lv%0d bits%02h", lv, mb));
        scan_copies("R6 copies");
        n++;
      end
    end
    finish_run();
  end

endmodule